// File: doc/BRIEF.md
# FP Issue Hazard Interlock Unit

This block sits at the decode stage of an in-order pipeline. The pipeline has five kinds of execution resource with different result delays: an integer ALU, a load/store path, a pipelined FP adder, a pipelined multiplier and a non-pipelined divider. Each cycle the decode stage presents one decoded instruction: its unit class, an optional destination register and up to two optional source registers. The block answers within the same cycle whether that instruction may issue. If it may not, it raises `stall` and reports the cause. Stalls happen only here, so an instruction that leaves decode can run to completion without being held again.

Three kinds of state make the decision. Each register has a countdown timer that gives the cycles left until its pending result can be forwarded. The divider has an occupancy counter. A write-back reservation vector records which future cycles already hold the single register write port. Timers, the counter and the reservation vector keep advancing every cycle, including stalled cycles. Only issuing records anything new.

Top module: `fp_issue_interlock`

## Requirements
- R1: After reset no result is pending, the divider is idle and no write-back slot is held, so the first instruction issues at once whatever registers it names.
- R2: Result latency (cycles between a producer issuing and a dependent instruction issuing) is 0 for unit code 0 (ALU), 1 for code 1 (load/store), 3 for code 2 (FP add), 6 for code 3 (multiply) and 24 for code 4 (divide). A consumer with an enabled source whose producer has not covered that latency is held (RAW). Register index bit 5 = 1 selects the FP file and bit 5 = 0 the integer file.
- R3: The divider accepts a new instruction no sooner than 25 cycles after the previous one. A divide that arrives earlier is held (structural).
- R4: A writing instruction with latency L claims the write port L cycles after issue. It is held if that cycle is already claimed.
- R5: A writing instruction is held if an earlier write to the same destination would still be pending when its own result arrives (WAW).
- R6: Disabled sources are not checked, a non-writing instruction is never held for write-port or WAW reasons, and with `dec_valid` low `stall` is 0.
- R7: `stall_why` bit 0 = structural, bit 1 = RAW, bit 2 = write port, bit 3 = WAW, with several bits possibly set together. `stall` is the OR of these bits, and `issue` = `dec_valid` and not `stall`. Unit codes 5 to 7 behave as the ALU.
- R8: While an instruction is held, all timers and reservations keep counting down, so it issues on exactly the first cycle its hazards clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_unit | input | 3 | Unit class code |
| dec_wr | input | 1 | Instruction writes a register |
| dec_dst | input | 6 | Destination register |
| dec_rs1_en | input | 1 | First source in use |
| dec_rs1 | input | 6 | First source register |
| dec_rs2_en | input | 1 | Second source in use |
| dec_rs2 | input | 6 | Second source register |
| stall | output | 1 | Hold the instruction in decode |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall_why | output | 4 | Stall cause bits |

## Verification
The write-port check and the RAW check can fire in the same cycle. The bench provokes this by issuing a load and, in the very next cycle, an ALU instruction that reads the load's destination and also writes a register. Both the port claim and the operand fall on that cycle, so the expected `stall_why` has bits 1 and 2 set for exactly one cycle. A load followed by an ALU write to the same destination likewise combines the port and WAW causes. The scoreboard judges these cycles against a model that tracks absolute ready cycles and does not use countdowns.

// File: rtl/fpil_pkg.sv
package fpil_pkg;
  localparam int NREG    = 64;
  localparam int RAW_W   = 6;
  localparam int LAT_W   = 5;
  localparam int LAT_ALU = 0;
  localparam int LAT_MEM = 1;
  localparam int LAT_ADD = 3;
  localparam int LAT_MUL = 6;
  localparam int LAT_DIV = 24;
  localparam int DIV_II  = 25;
  localparam int RES_DEPTH = LAT_DIV + 1;

  localparam logic [2:0] UC_ALU = 3'd0;
  localparam logic [2:0] UC_MEM = 3'd1;
  localparam logic [2:0] UC_ADD = 3'd2;
  localparam logic [2:0] UC_MUL = 3'd3;
  localparam logic [2:0] UC_DIV = 3'd4;

  // result latency of a unit class; unknown codes act as the ALU
  function automatic logic [LAT_W-1:0] unit_lat(input logic [2:0] uc);
    case (uc)
      UC_MEM:  return LAT_W'(LAT_MEM);
      UC_ADD:  return LAT_W'(LAT_ADD);
      UC_MUL:  return LAT_W'(LAT_MUL);
      UC_DIV:  return LAT_W'(LAT_DIV);
      default: return LAT_W'(LAT_ALU);
    endcase
  endfunction

  function automatic logic is_div(input logic [2:0] uc);
    return uc == UC_DIV;
  endfunction
endpackage

// File: rtl/fpil_timers.sv
module fpil_timers #(
  parameter int NR = 64,
  parameter int TW = 5,
  parameter int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  logic [TW-1:0] set_val,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  input  logic [AW-1:0] rd_d_idx,
  output logic [TW-1:0] rd_a_val,
  output logic [TW-1:0] rd_b_val,
  output logic [TW-1:0] rd_d_val
);
  logic [TW-1:0] tmr [NR];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NR; i++) begin
      if (!rst_n)                              tmr[i] <= '0;
      else if (set_en && set_idx == AW'(i))    tmr[i] <= set_val;
      else if (tmr[i] != '0)                   tmr[i] <= tmr[i] - TW'(1);
    end
  end

  assign rd_a_val = tmr[rd_a_idx];
  assign rd_b_val = tmr[rd_b_idx];
  assign rd_d_val = tmr[rd_d_idx];

  // R2
  timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> tmr[$past(set_idx)] == $past(set_val));
endmodule

// File: rtl/fpil_wbres.sv
module fpil_wbres #(
  parameter int DEPTH = 25,
  parameter int LW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          book_en,
  input  logic [LW-1:0] book_off,
  input  logic [LW-1:0] probe_off,
  output logic          probe_hit
);
  logic [DEPTH-1:0] res_q;
  logic [DEPTH-1:0] res_set;
  logic [LW-1:0]    off_m1_q;
  logic             booked_q;

  assign res_set   = res_q | (book_en ? (DEPTH'(1) << book_off) : '0);
  assign probe_hit = res_q[probe_off];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q    <= '0;
      off_m1_q <= '0;
      booked_q <= 1'b0;
    end else begin
      res_q    <= res_set >> 1;
      off_m1_q <= book_off - LW'(1);
      booked_q <= book_en && (book_off != '0);
    end
  end

  // R4
  port_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    book_en |-> !res_q[book_off]);
  // R4
  port_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    booked_q |-> res_q[off_m1_q]);
endmodule

// File: rtl/fpil_divbusy.sv
module fpil_divbusy #(
  parameter int II = 25,
  parameter int CW = $clog2(II)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(II - 1);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = cnt != '0;

  // R3
  div_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import fpil_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [2:0]       dec_unit,
  input  logic             dec_wr,
  input  logic [RAW_W-1:0] dec_dst,
  input  logic             dec_rs1_en,
  input  logic [RAW_W-1:0] dec_rs1,
  input  logic             dec_rs2_en,
  input  logic [RAW_W-1:0] dec_rs2,
  output logic             stall,
  output logic             issue,
  output logic [3:0]       stall_why
);
  logic [LAT_W-1:0] lat;
  logic [LAT_W-1:0] t_a, t_b, t_d;
  logic             port_hit, div_busy;
  logic             hz_struct, hz_raw, hz_port, hz_waw;
  logic             rec_write, rec_div;

  assign lat = unit_lat(dec_unit);

  fpil_timers #(.NR(NREG), .TW(LAT_W), .AW(RAW_W)) u_timers (
    .clk(clk), .rst_n(rst_n),
    .set_en(rec_write), .set_idx(dec_dst), .set_val(lat),
    .rd_a_idx(dec_rs1), .rd_b_idx(dec_rs2), .rd_d_idx(dec_dst),
    .rd_a_val(t_a), .rd_b_val(t_b), .rd_d_val(t_d)
  );

  fpil_wbres #(.DEPTH(RES_DEPTH), .LW(LAT_W)) u_wbres (
    .clk(clk), .rst_n(rst_n),
    .book_en(rec_write), .book_off(lat),
    .probe_off(lat), .probe_hit(port_hit)
  );

  fpil_divbusy #(.II(DIV_II)) u_divbusy (
    .clk(clk), .rst_n(rst_n), .start(rec_div), .busy(div_busy)
  );

  assign hz_struct = dec_valid && is_div(dec_unit) && div_busy;
  assign hz_raw    = dec_valid && ((dec_rs1_en && t_a != '0) ||
                                   (dec_rs2_en && t_b != '0));
  assign hz_port   = dec_valid && dec_wr && port_hit;
  assign hz_waw    = dec_valid && dec_wr && (t_d > lat);

  assign stall_why = {hz_waw, hz_port, hz_raw, hz_struct};
  assign stall     = |stall_why;
  assign issue     = dec_valid && !stall;
  assign rec_write = issue && dec_wr;
  assign rec_div   = issue && is_div(dec_unit);

  // R6
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !stall);
  // R2
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && dec_rs1_en |-> t_a == '0);
  // R5
  waw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_write |-> t_d <= lat);
endmodule

// File: tb/fp_issue_interlock_bench.sv
module fp_issue_interlock_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, dec_wr = 1'b0, dec_rs1_en = 1'b0, dec_rs2_en = 1'b0;
  logic [2:0] dec_unit = 3'd0;
  logic [5:0] dec_dst = '0, dec_rs1 = '0, dec_rs2 = '0;
  logic stall, issue;
  logic [3:0] stall_why;

  always #5 clk = ~clk;

  fp_issue_interlock u_fp_issue_interlock (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
    .dec_wr(dec_wr), .dec_dst(dec_dst), .dec_rs1_en(dec_rs1_en),
    .dec_rs1(dec_rs1), .dec_rs2_en(dec_rs2_en), .dec_rs2(dec_rs2),
    .stall(stall), .issue(issue), .stall_why(stall_why)
  );

  typedef struct { bit st; bit iss; bit [3:0] why; string tag; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  int cyc = 0;
  int ready_at [64];
  int div_free_at = 0;
  bit port_taken [int];
  int lat_tab [8] = '{0, 1, 3, 6, 24, 0, 0, 0};

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: compare each driven cycle against the scoreboard
  initial forever begin
    @(negedge clk); #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(stall == e.st, {e.tag, " stall"}, int'(stall), int'(e.st));
      check(stall_why == e.why, {e.tag, " R7 why"}, int'(stall_why), int'(e.why));
      check(issue == e.iss, {e.tag, " R7 issue"}, int'(issue), int'(e.iss));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      dec_valid = 1'b0;
      e.st = 0; e.iss = 0; e.why = 4'h0; e.tag = "R6 idle";
      q.push_back(e);
    end
  endtask

  task automatic send(input logic [2:0] u, input bit wr, input logic [5:0] d,
                      input bit e1, input logic [5:0] s1, input bit e2,
                      input logic [5:0] s2, input string tag, output int nst);
    bit done = 0;
    nst = 0;
    while (!done) begin
      exp_t e;
      int lt;
      @(negedge clk);
      dec_valid = 1'b1; dec_unit = u; dec_wr = wr; dec_dst = d;
      dec_rs1_en = e1; dec_rs1 = s1; dec_rs2_en = e2; dec_rs2 = s2;
      lt = lat_tab[u];
      e.why[0] = (u == 3'd4) && (div_free_at > cyc);
      e.why[1] = (e1 && ready_at[s1] > cyc) || (e2 && ready_at[s2] > cyc);
      e.why[2] = wr && port_taken.exists(cyc + lt);
      e.why[3] = wr && (ready_at[d] > cyc + lt);
      e.st = |e.why; e.iss = !e.st; e.tag = tag;
      q.push_back(e);
      if (e.st) nst++;
      else begin
        if (wr) begin
          ready_at[d] = cyc + 1 + lt;
          port_taken[cyc + lt] = 1'b1;
        end
        if (u == 3'd4) div_free_at = cyc + 25;
        done = 1;
      end
    end
  endtask

  initial begin
    int n;
    for (int i = 0; i < 64; i++) ready_at[i] = 0;
    repeat (3) @(negedge clk);
    check(stall == 1'b0 && issue == 1'b0, "R1 reset outputs", int'(stall), 0);
    rst_n = 1'b1;
    // R1: first instruction reading anything issues at once
    send(3'd3, 1, 6'd33, 1, 6'd34, 1, 6'd5, "R1 first", n);
    check(n == 0, "R1 first issue stalls", n, 0);
    idle(10);
    // R2: ALU producer, ALU consumer next cycle: zero latency
    send(3'd0, 1, 6'd5, 0, 0, 0, 0, "R2 alu prod", n);
    send(3'd0, 1, 6'd6, 1, 6'd5, 0, 0, "R2 alu cons", n);
    check(n == 0, "R2 alu latency stalls", n, 0);
    idle(5);
    // R2: load then dependent FP add: one stall
    send(3'd1, 1, 6'd33, 0, 0, 0, 0, "R2 load", n);
    send(3'd2, 1, 6'd35, 1, 6'd33, 0, 0, "R2 load use", n);
    check(n == 1, "R2 load use stalls", n, 1);
    idle(10);
    // R2/R8: multiply then dependent add: six stalls
    send(3'd3, 1, 6'd34, 0, 0, 0, 0, "R2 mul", n);
    send(3'd2, 1, 6'd36, 0, 0, 1, 6'd34, "R8 mul use", n);
    check(n == 6, "R2 mul use stalls", n, 6);
    idle(10);
    // R3: back-to-back divides
    send(3'd4, 1, 6'd36, 0, 0, 0, 0, "R3 div a", n);
    send(3'd4, 1, 6'd37, 0, 0, 0, 0, "R3 div b", n);
    check(n == 24, "R3 divider interval stalls", n, 24);
    idle(30);
    // R4: multiply and later add land on the same write-back cycle
    send(3'd3, 1, 6'd38, 0, 0, 0, 0, "R4 mul", n);
    send(3'd0, 1, 6'd7, 0, 0, 0, 0, "R4 alu1", n);
    send(3'd0, 1, 6'd8, 0, 0, 0, 0, "R4 alu2", n);
    send(3'd2, 1, 6'd39, 0, 0, 0, 0, "R4 add", n);
    check(n == 1, "R4 port collision stalls", n, 1);
    idle(10);
    // R5: divide then add to same destination
    send(3'd4, 1, 6'd40, 0, 0, 0, 0, "R5 div", n);
    send(3'd2, 1, 6'd40, 0, 0, 0, 0, "R5 add same dst", n);
    check(n == 21, "R5 waw stalls", n, 21);
    idle(30);
    // R2+R4 same cycle: load, then ALU reading it and writing
    send(3'd1, 1, 6'd41, 0, 0, 0, 0, "R4 load", n);
    send(3'd0, 1, 6'd9, 1, 6'd41, 0, 0, "R2 R4 combined", n);
    check(n == 1, "R4 combined stalls", n, 1);
    idle(5);
    // R5+R4: load then ALU to same destination
    send(3'd1, 1, 6'd10, 0, 0, 0, 0, "R5 load", n);
    send(3'd0, 1, 6'd10, 0, 0, 0, 0, "R5 R4 alu same dst", n);
    check(n == 1, "R5 combined stalls", n, 1);
    idle(5);
    // R6: disabled source and non-writing store ignore pending state
    send(3'd3, 1, 6'd42, 0, 0, 0, 0, "R6 mul", n);
    send(3'd2, 1, 6'd43, 0, 6'd42, 0, 6'd42, "R6 disabled src", n);
    check(n == 0, "R6 disabled source stalls", n, 0);
    send(3'd1, 0, 6'd42, 0, 0, 0, 0, "R6 store no write", n);
    check(n == 0, "R6 store stalls", n, 0);
    idle(10);
    // R7: codes 5..7 behave as ALU
    send(3'd7, 1, 6'd11, 0, 0, 0, 0, "R7 code7", n);
    send(3'd5, 1, 6'd12, 1, 6'd11, 0, 0, "R7 code5 use", n);
    check(n == 0, "R7 odd codes stalls", n, 0);
    // R2: pipelined adder accepts every cycle
    send(3'd2, 1, 6'd44, 0, 0, 0, 0, "R2 add1", n);
    send(3'd2, 1, 6'd45, 0, 0, 0, 0, "R2 add2", n);
    check(n == 0, "R2 adder interval stalls", n, 0);
    idle(5);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule